// File: doc/BRIEF.md
# Directory-Protocol Cache Coherence Controller (MSI, Cache Side)

This block sits between one processor and the coherence network of a node. It holds a small direct-mapped array of one-word lines. Each line carries a tag, its data and one of three coherence states: Modified, Shared or Invalid. Loads and stores that hit are answered locally. A load that misses sends a read request to the home directory of the block. A store that misses, or a store to a Shared line, sends an exclusive read request. The home node is computed from the block address. Only one miss may be outstanding at a time, and the processor port stalls until the matching reply arrives.

The directory can reach into the cache while a miss is pending. An invalidate request is always acknowledged, whether or not the line is present. A recall makes a Modified line return its data, and the line then drops to Shared (read recall) or to Invalid (write recall). A NACK makes the controller send its pending request again. When a fill needs the slot of a Modified line holding another block, the old line is first sent back as a writeback.

Messages travel on one outbound channel and one inbound channel. Each message is a single-cycle valid pulse with a type, a word address and one data word. There is no back-pressure on either channel. An incoming probe has priority over an outgoing request. The processor port is not ready in any cycle that carries an inbound message.

Top module: `msi_cache_ctrl`

## Requirements
- R1: After reset, out_valid and cpu_resp_valid are 0, cpu_req_ready is 1, and every line is Invalid, so the first access to any address misses.
- R2: Every outbound message carries out_home = (out_addr >> 2) mod NODES, where the block address is the word address above the 2-bit byte offset.
- R3: A load that misses sends a read request (out_type 1) for the load address. A read reply (in_type 1) fills the line as Shared and returns in_data on cpu_resp_data. A later load to the same address returns that data without sending any message.
- R4: A store that misses sends an exclusive request (out_type 2). An exclusive reply (in_type 2) leaves the line Modified, holding the store data, and cpu_resp_data echoes the store data. A later store or load to a Modified line completes with no message.
- R5: A store to a Shared line sends an exclusive request (out_type 2) for that address before it completes.
- R6: An invalidate request (in_type 3) is always answered the next cycle by an invalidate reply (out_type 4) with the same address. A present line becomes Invalid. An invalidate whose tag does not match the line leaves the line unchanged.
- R7: A read recall (in_type 4) of a Modified line is answered by a recall reply (out_type 5) carrying the line data, and the line becomes Shared.
- R8: A write recall (in_type 5) of a Modified line is answered by a recall reply (out_type 5) carrying the line data, and the line becomes Invalid.
- R9: A NACK (in_type 6) to a pending request makes the controller send the same request type and address again.
- R10: A miss whose slot holds a Modified line of another block first sends a writeback (out_type 3) with that block's address and data, and then sends the request for the new address.
- R11: While a miss is pending, cpu_req_ready is 0. Invalidates and recalls that arrive while waiting are still answered, and the pending miss then completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | ADDR_W | Byte address of the access |
| cpu_req_wdata | input | DATA_W | Store data |
| cpu_req_ready | output | 1 | Request accepted in this cycle when high |
| cpu_resp_valid | output | 1 | One-cycle completion pulse |
| cpu_resp_data | output | DATA_W | Load data, or the store data for a store |
| out_valid | output | 1 | Outbound message pulse |
| out_type | output | 3 | 1 read req, 2 exclusive req, 3 writeback, 4 invalidate reply, 5 recall reply |
| out_addr | output | ADDR_W | Block address of the message |
| out_home | output | NODE_W | Destination home node |
| out_data | output | DATA_W | Line data for writeback and recall reply |
| in_valid | input | 1 | Inbound message pulse |
| in_type | input | 3 | 1 read reply, 2 exclusive reply, 3 invalidate, 4 read recall, 5 write recall, 6 NACK |
| in_addr | input | ADDR_W | Block address of the message |
| in_data | input | DATA_W | Fill data for replies |

## Verification
The main function is exercised with four kinds of access: load misses, load hits, store misses and stores to lines already Shared or Modified. Together they separate the three line states by the message each access produces, or by the absence of any message. Probes are sent to present and absent tags, to Shared and Modified lines, and during an outstanding miss. This tells a correct tag compare apart from one that acts on the index alone. It also shows the difference between a downgrade and an invalidate, because the access that follows the probe either hits or misses. Evictions and NACKs check message order: the writeback must come before the new request, and the request must repeat after a refusal.

// File: rtl/msi_cache_ctrl.sv
module msi_cache_ctrl #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LINES  = 4,
  parameter int NODES  = 3,
  parameter int OFF_W  = 2,
  localparam int IDX_W  = $clog2(LINES),
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W,
  localparam int NODE_W = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_req_ready,
  output logic              cpu_resp_valid,
  output logic [DATA_W-1:0] cpu_resp_data,
  output logic              out_valid,
  output logic [2:0]        out_type,
  output logic [ADDR_W-1:0] out_addr,
  output logic [NODE_W-1:0] out_home,
  output logic [DATA_W-1:0] out_data,
  input  logic              in_valid,
  input  logic [2:0]        in_type,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data
);
  localparam logic [1:0] ST_I = 2'd0, ST_S = 2'd1, ST_M = 2'd2;
  localparam logic [2:0] O_RD = 3'd1, O_RDX = 3'd2, O_WB = 3'd3, O_INVR = 3'd4, O_RCLR = 3'd5;
  localparam logic [2:0] I_RDR = 3'd1, I_EXR = 3'd2, I_INV = 3'd3, I_RCRD = 3'd4, I_RCWR = 3'd5,
                         I_NACK = 3'd6;

  typedef enum logic [1:0] {F_IDLE, F_EVICT, F_REQ, F_WAIT} fsm_t;

  logic [1:0]        st_q   [LINES];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  fsm_t              fsm_q;
  logic              rq_write;
  logic [ADDR_W-1:0] rq_addr;
  logic [DATA_W-1:0] rq_wdata;

  logic [IDX_W-1:0] c_idx, p_idx, r_idx;
  logic [TAG_W-1:0] c_tag, p_tag, r_tag;
  logic             probe, p_match, c_match;

  assign c_idx = cpu_req_addr[OFF_W +: IDX_W];
  assign c_tag = cpu_req_addr[ADDR_W-1 -: TAG_W];
  assign p_idx = in_addr[OFF_W +: IDX_W];
  assign p_tag = in_addr[ADDR_W-1 -: TAG_W];
  assign r_idx = rq_addr[OFF_W +: IDX_W];
  assign r_tag = rq_addr[ADDR_W-1 -: TAG_W];

  assign probe   = in_valid && (in_type == I_INV || in_type == I_RCRD || in_type == I_RCWR);
  assign p_match = (st_q[p_idx] != ST_I) && (tag_q[p_idx] == p_tag);
  assign c_match = (st_q[c_idx] != ST_I) && (tag_q[c_idx] == c_tag);

  assign cpu_req_ready = (fsm_q == F_IDLE) && !in_valid;
  assign out_home = NODE_W'((out_addr >> OFF_W) % NODES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        st_q[i]   <= ST_I;
        tag_q[i]  <= '0;
        data_q[i] <= '0;
      end
      fsm_q          <= F_IDLE;
      rq_write       <= 1'b0;
      rq_addr        <= '0;
      rq_wdata       <= '0;
      cpu_resp_valid <= 1'b0;
      cpu_resp_data  <= '0;
      out_valid      <= 1'b0;
      out_type       <= '0;
      out_addr       <= '0;
      out_data       <= '0;
    end else begin
      cpu_resp_valid <= 1'b0;
      out_valid      <= 1'b0;
      if (probe) begin
        out_valid <= 1'b1;
        out_addr  <= in_addr;
        if (in_type == I_INV) begin
          out_type <= O_INVR;
          out_data <= '0;
          if (p_match) st_q[p_idx] <= ST_I;
        end else begin
          out_type <= O_RCLR;
          if (p_match && st_q[p_idx] == ST_M) begin
            out_data    <= data_q[p_idx];
            st_q[p_idx] <= (in_type == I_RCRD) ? ST_S : ST_I;
          end else begin
            out_data <= '0;
          end
        end
      end else begin
        case (fsm_q)
          F_IDLE: if (cpu_req_valid && cpu_req_ready) begin
            if (!cpu_req_write && c_match) begin
              cpu_resp_valid <= 1'b1;
              cpu_resp_data  <= data_q[c_idx];
            end else if (cpu_req_write && c_match && st_q[c_idx] == ST_M) begin
              data_q[c_idx]  <= cpu_req_wdata;
              cpu_resp_valid <= 1'b1;
              cpu_resp_data  <= cpu_req_wdata;
            end else begin
              rq_write <= cpu_req_write;
              rq_addr  <= cpu_req_addr;
              rq_wdata <= cpu_req_wdata;
              fsm_q    <= (!c_match && st_q[c_idx] == ST_M) ? F_EVICT : F_REQ;
            end
          end
          F_EVICT: begin
            if (st_q[r_idx] == ST_M && tag_q[r_idx] != r_tag) begin
              out_valid   <= 1'b1;
              out_type    <= O_WB;
              out_addr    <= {tag_q[r_idx], r_idx, {OFF_W{1'b0}}};
              out_data    <= data_q[r_idx];
              st_q[r_idx] <= ST_I;
            end
            fsm_q <= F_REQ;
          end
          F_REQ: begin
            out_valid <= 1'b1;
            out_type  <= rq_write ? O_RDX : O_RD;
            out_addr  <= rq_addr;
            out_data  <= '0;
            fsm_q     <= F_WAIT;
          end
          F_WAIT: if (in_valid) begin
            if (in_type == I_NACK) begin
              fsm_q <= F_REQ;
            end else if (in_type == I_RDR && !rq_write) begin
              st_q[r_idx]    <= ST_S;
              tag_q[r_idx]   <= r_tag;
              data_q[r_idx]  <= in_data;
              cpu_resp_valid <= 1'b1;
              cpu_resp_data  <= in_data;
              fsm_q          <= F_IDLE;
            end else if (in_type == I_EXR && rq_write) begin
              st_q[r_idx]    <= ST_M;
              tag_q[r_idx]   <= r_tag;
              data_q[r_idx]  <= rq_wdata;
              cpu_resp_valid <= 1'b1;
              cpu_resp_data  <= rq_wdata;
              fsm_q          <= F_IDLE;
            end
          end
          default: fsm_q <= F_IDLE;
        endcase
      end
    end
  end

  assert_read_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_q == F_WAIT && in_valid && in_type == I_RDR && !rq_write)
      |=> (cpu_resp_valid && cpu_resp_data == $past(in_data)));

  assert_inv_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_type == I_INV)
      |=> (out_valid && out_type == O_INVR && out_addr == $past(in_addr)));

  assert_nack_retry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_q == F_WAIT && in_valid && in_type == I_NACK) |=> (fsm_q == F_REQ));

  assert_wb_from_evict_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_type == O_WB) |-> ($past(fsm_q) == F_EVICT && fsm_q == F_REQ));

  assert_wait_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_q == F_WAIT && $past(fsm_q) == F_WAIT && out_valid)
      |-> (out_type == O_INVR || out_type == O_RCLR));

  assert_resp_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_resp_valid |-> (fsm_q == F_IDLE));
endmodule

// File: tb/msi_cache_ctrl_test.sv
`timescale 1ns/1ps
module msi_cache_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
  logic [15:0] cpu_req_addr = '0;
  logic [31:0] cpu_req_wdata = '0;
  logic        cpu_req_ready, cpu_resp_valid;
  logic [31:0] cpu_resp_data;
  logic        out_valid;
  logic [2:0]  out_type;
  logic [15:0] out_addr;
  logic [1:0]  out_home;
  logic [31:0] out_data;
  logic        in_valid = 1'b0;
  logic [2:0]  in_type = '0;
  logic [15:0] in_addr = '0;
  logic [31:0] in_data = '0;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  msi_cache_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
    .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
    .cpu_req_ready(cpu_req_ready), .cpu_resp_valid(cpu_resp_valid),
    .cpu_resp_data(cpu_resp_data),
    .out_valid(out_valid), .out_type(out_type), .out_addr(out_addr),
    .out_home(out_home), .out_data(out_data),
    .in_valid(in_valid), .in_type(in_type), .in_addr(in_addr), .in_data(in_data)
  );

  typedef struct packed {
    logic        w;
    logic [15:0] a;
    logic [31:0] d;
    logic [2:0]  msg;
    logic [2:0]  rep;
    logic [31:0] rd;
    logic [31:0] resp;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 16'h0010, 32'h0,         3'd1, 3'd1, 32'hA0A00001, 32'hA0A00001},
    '{1'b0, 16'h0010, 32'h0,         3'd0, 3'd0, 32'h0,        32'hA0A00001},
    '{1'b1, 16'h0024, 32'hBEEF0002,  3'd2, 3'd2, 32'h00001111, 32'hBEEF0002},
    '{1'b0, 16'h0024, 32'h0,         3'd0, 3'd0, 32'h0,        32'hBEEF0002},
    '{1'b1, 16'h0024, 32'hCAFE0003,  3'd0, 3'd0, 32'h0,        32'hCAFE0003},
    '{1'b1, 16'h0010, 32'h55550004,  3'd2, 3'd2, 32'h00002222, 32'h55550004},
    '{1'b0, 16'h0038, 32'h0,         3'd1, 3'd1, 32'h33330005, 32'h33330005}
  };

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cpu_issue(input logic w, input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    chk(cpu_req_ready, "R11 ready before issue", 32'(cpu_req_ready), 32'd1);
    cpu_req_valid = 1'b1; cpu_req_write = w; cpu_req_addr = a; cpu_req_wdata = d;
    @(negedge clk);
    cpu_req_valid = 1'b0;
  endtask

  task automatic send_in(input logic [2:0] t, input logic [15:0] a, input logic [31:0] d);
    in_valid = 1'b1; in_type = t; in_addr = a; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_msg(input logic [2:0] t, input logic [15:0] a, input logic chk_d,
                            input logic [31:0] d, input string tag);
    for (int i = 0; i < 6 && !out_valid; i++) @(negedge clk);
    chk(out_valid, {tag, " message present"}, 32'(out_valid), 32'd1);
    chk(out_type == t, {tag, " type"}, 32'(out_type), 32'(t));
    chk(out_addr == a, {tag, " addr"}, 32'(out_addr), 32'(a));
    chk(32'(out_home) == (32'(a) >> 2) % 3, "R2 home node", 32'(out_home), (32'(a) >> 2) % 3);
    if (chk_d) chk(out_data == d, {tag, " data"}, out_data, d);
    @(negedge clk);
  endtask

  task automatic expect_resp(input logic [31:0] d, input string tag);
    for (int i = 0; i < 6 && !cpu_resp_valid; i++) @(negedge clk);
    chk(cpu_resp_valid, {tag, " resp present"}, 32'(cpu_resp_valid), 32'd1);
    chk(cpu_resp_data == d, {tag, " resp data"}, cpu_resp_data, d);
  endtask

  task automatic expect_quiet(input int n, input string tag);
    logic seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (out_valid) seen = 1'b1;
      @(negedge clk);
    end
    chk(!seen, {tag, " no message"}, 32'(seen), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(!out_valid, "R1 out_valid after reset", 32'(out_valid), 32'd0);
    chk(!cpu_resp_valid, "R1 resp_valid after reset", 32'(cpu_resp_valid), 32'd0);
    chk(cpu_req_ready, "R1 ready after reset", 32'(cpu_req_ready), 32'd1);

    for (int i = 0; i < NV; i++) begin
      cpu_issue(VEC[i].w, VEC[i].a, VEC[i].d);
      if (VEC[i].msg != 3'd0) begin
        expect_msg(VEC[i].msg, VEC[i].a, 1'b0, 32'h0, VEC[i].w ? "R4/R5 exclusive req" : "R3 read req");
        send_in(VEC[i].rep, VEC[i].a, VEC[i].rd);
        expect_resp(VEC[i].resp, VEC[i].w ? "R4 store fill" : "R3 load fill");
      end else begin
        expect_resp(VEC[i].resp, VEC[i].w ? "R4 store hit" : "R3 load hit");
        expect_quiet(3, "R3/R4 hit");
      end
    end

    // R10 eviction of Modified line 0x0024 by load 0x0064
    cpu_issue(1'b0, 16'h0064, 32'h0);
    expect_msg(3'd3, 16'h0024, 1'b1, 32'hCAFE0003, "R10 writeback");
    expect_msg(3'd1, 16'h0064, 1'b0, 32'h0, "R10 request after writeback");
    send_in(3'd1, 16'h0064, 32'h64640006);
    expect_resp(32'h64640006, "R10 fill");

    // R6 invalidate of present Shared line, then reload misses
    send_in(3'd3, 16'h0038, 32'h0);
    expect_msg(3'd4, 16'h0038, 1'b0, 32'h0, "R6 inv reply present");
    cpu_issue(1'b0, 16'h0038, 32'h0);
    expect_msg(3'd1, 16'h0038, 1'b0, 32'h0, "R6 miss after invalidate");
    send_in(3'd1, 16'h0038, 32'h38380007);
    expect_resp(32'h38380007, "R6 refill");

    // R6 invalidate with non-matching tag leaves Modified 0x0010
    send_in(3'd3, 16'h0F00, 32'h0);
    expect_msg(3'd4, 16'h0F00, 1'b0, 32'h0, "R6 inv reply absent");
    cpu_issue(1'b0, 16'h0010, 32'h0);
    expect_resp(32'h55550004, "R6 absent inv no effect");
    expect_quiet(3, "R6 absent inv hit");

    // R7 read recall: data returned, line Shared
    send_in(3'd4, 16'h0010, 32'h0);
    expect_msg(3'd5, 16'h0010, 1'b1, 32'h55550004, "R7 recall reply");
    cpu_issue(1'b0, 16'h0010, 32'h0);
    expect_resp(32'h55550004, "R7 load hits after downgrade");
    expect_quiet(3, "R7 shared hit");
    cpu_issue(1'b1, 16'h0010, 32'h77770008);
    expect_msg(3'd2, 16'h0010, 1'b0, 32'h0, "R7 store needs upgrade");
    send_in(3'd2, 16'h0010, 32'h0);
    expect_resp(32'h77770008, "R7 upgrade store");

    // R8 write recall: data returned, line Invalid
    send_in(3'd5, 16'h0010, 32'h0);
    expect_msg(3'd5, 16'h0010, 1'b1, 32'h77770008, "R8 recall reply");
    cpu_issue(1'b0, 16'h0010, 32'h0);
    expect_msg(3'd1, 16'h0010, 1'b0, 32'h0, "R8 miss after write recall");
    send_in(3'd1, 16'h0010, 32'h88880009);
    expect_resp(32'h88880009, "R8 refill");

    // R9 NACK and retry
    cpu_issue(1'b0, 16'h0074, 32'h0);
    expect_msg(3'd1, 16'h0074, 1'b0, 32'h0, "R9 first request");
    send_in(3'd6, 16'h0074, 32'h0);
    expect_msg(3'd1, 16'h0074, 1'b0, 32'h0, "R9 retried request");
    send_in(3'd1, 16'h0074, 32'h7474000A);
    expect_resp(32'h7474000A, "R9 fill after retry");

    // R11 probe handled during an outstanding miss
    cpu_issue(1'b1, 16'h0088, 32'h8888000B);
    expect_msg(3'd2, 16'h0088, 1'b0, 32'h0, "R11 pending request");
    chk(!cpu_req_ready, "R11 stalled while pending", 32'(cpu_req_ready), 32'd0);
    send_in(3'd3, 16'h0010, 32'h0);
    expect_msg(3'd4, 16'h0010, 1'b0, 32'h0, "R11 inv reply while waiting");
    chk(!cpu_req_ready, "R11 still stalled", 32'(cpu_req_ready), 32'd0);
    send_in(3'd2, 16'h0088, 32'h0);
    expect_resp(32'h8888000B, "R11 miss completes");
    cpu_issue(1'b0, 16'h0010, 32'h0);
    expect_msg(3'd1, 16'h0010, 1'b0, 32'h0, "R11 invalidated line misses");
    send_in(3'd1, 16'h0010, 32'h1010000C);
    expect_resp(32'h1010000C, "R11 refill");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule